// File: doc/BRIEF.md
# VGA Pass-Through Capture Path

This block takes an 8-bit palette index and its blank, horizontal-sync and vertical-sync companions from a legacy graphics feature port. It registers them on the port's own clock and carries them through a delay line of adjustable length. From there they meet the main pixel path at a common output stage. A mode-control bit chooses which of the two streams feeds the palette lookup. After reset, that bit selects the legacy port. The same bit also overrides the input clock-source selection.

When the frame buffer runs in self-clocked timing, the legacy stream gets `EXTRA_DLY` additional dot-clock stages, where `EXTRA_DLY` is a parameter from 0 to 7. These stages match the delay that the pixel path sees, so the output does not jump in time when the source is switched. Data and the three control signals always share one delay. When the timing select changes, the output is held blanked until the delay line has refilled. While blank is high, the output index is forced to zero.

Top module: `vgapt_path`

## Requirements
- R1: With the legacy port selected and self-clocked timing off, `out_idx`, `out_blank`, `out_hs` and `out_vs` reproduce the legacy inputs 2 clock edges after they are sampled.
- R2: With self-clocked timing on (`self_clk`=1), the legacy latency becomes 2+`EXTRA_DLY` edges, identically for index, blank and both syncs. `EXTRA_DLY` must lie in 0..7 and is checked at elaboration.
- R3: With the pixel path selected, its inputs reach the outputs 2 edges after sampling, whatever the value of `self_clk`.
- R4: A write strobe `ctl_wr` loads bit 7 of `ctl_data` as the source bit (1 = legacy port, 0 = pixel path). The output produced at the edge following the write uses the new source.
- R5: During and right after reset, the legacy port is selected and the outputs read blank=1, index 0, hs=0, vs=0.
- R6: `clk_src` is 2'b00 (the legacy port clock) while the source bit is 1, and equals `clk_sel` otherwise.
- R7: Whenever `out_blank` is 1, `out_idx` is 0.
- R8: If `self_clk` differs from its value at the previous edge, the outputs at that edge and at the next `EXTRA_DLY`+1 edges are blank=1, index 0, hs=0, vs=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, the same clock as the legacy port |
| rst_n | input | 1 | Active-low synchronous reset |
| vga_idx | input | IDX_W | Legacy port index |
| vga_blank | input | 1 | Legacy port blank |
| vga_hs | input | 1 | Legacy port horizontal sync |
| vga_vs | input | 1 | Legacy port vertical sync |
| pix_idx | input | IDX_W | Pixel path index |
| pix_blank | input | 1 | Pixel path blank |
| pix_hs | input | 1 | Pixel path horizontal sync |
| pix_vs | input | 1 | Pixel path vertical sync |
| self_clk | input | 1 | Frame-buffer timing: 1 = self-clocked |
| ctl_wr | input | 1 | Mode-control write strobe |
| ctl_data | input | 8 | Mode-control data; bit 7 = source bit |
| clk_sel | input | 2 | Requested input clock source |
| clk_src | output | 2 | Effective input clock source |
| out_idx | output | IDX_W | Index to the palette |
| out_blank | output | 1 | Blank to the palette |
| out_hs | output | 1 | Horizontal sync out |
| out_vs | output | 1 | Vertical sync out |

## Verification
The bench builds the block with `IDX_W`=8 and `EXTRA_DLY`=3. With these values the long and short legacy latencies differ by three edges, so an off-by-one in the tap select or in the stage count shows up as an index mismatch. The flush window covers five edges, which makes a window that is one edge too short or too long visible. Random timing-select toggles and source writes land at many different distances from each other, which exercises both the flush and the path-switch ordering.

// File: rtl/vgapt_pkg.sv
package vgapt_pkg;
   localparam int unsigned IDX_W = 8;

   typedef struct packed {
      logic             vs;
      logic             hs;
      logic             blank;
      logic [IDX_W-1:0] idx;
   } beat_t;

   function automatic beat_t idle_beat();
      beat_t b;
      b.vs    = 1'b0;
      b.hs    = 1'b0;
      b.blank = 1'b1;
      b.idx   = '0;
      return b;
   endfunction
endpackage

// File: rtl/vgapt_capture.sv
module vgapt_capture
   import vgapt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  beat_t d,
   output beat_t q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= idle_beat();
      else        q <= d;
   end

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && $past(rst_n) |-> q == $past(d));
endmodule

// File: rtl/vgapt_delay.sv
module vgapt_delay
   import vgapt_pkg::*;
#(
   parameter int unsigned EXTRA_DLY = 3
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  use_extra,
   input  beat_t d,
   output beat_t q
);
   generate
      if (EXTRA_DLY == 0) begin : g_none
         assign q = d;
      end else begin : g_line
         beat_t stage [EXTRA_DLY];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(EXTRA_DLY); i++) stage[i] <= idle_beat();
            end else begin
               stage[0] <= d;
               for (int i = 1; i < int'(EXTRA_DLY); i++) stage[i] <= stage[i-1];
            end
         end
         assign q = use_extra ? stage[EXTRA_DLY-1] : d;
      end
   endgenerate
endmodule

// File: rtl/vgapt_outstage.sv
module vgapt_outstage
   import vgapt_pkg::*;
#(
   parameter int unsigned EXTRA_DLY = 3
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  self_clk,
   input  logic  use_vga,
   input  beat_t vga_b,
   input  beat_t pix_b,
   output beat_t q
);
   localparam int unsigned FLUSH_LEN = EXTRA_DLY + 1;
   localparam int unsigned CNT_W     = $clog2(FLUSH_LEN + 1) + 1;

   logic             self_q;
   logic [CNT_W-1:0] flush_cnt;
   logic             changed;
   logic             flushing;
   beat_t            pick;

   assign changed  = self_clk != self_q;
   assign flushing = changed || (flush_cnt != '0);
   assign pick     = use_vga ? vga_b : pix_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         self_q    <= 1'b0;
         flush_cnt <= '0;
         q         <= idle_beat();
      end else begin
         self_q <= self_clk;
         if (changed)              flush_cnt <= CNT_W'(FLUSH_LEN);
         else if (flush_cnt != '0) flush_cnt <= flush_cnt - 1'b1;
         if (flushing) begin
            q <= idle_beat();
         end else begin
            q     <= pick;
            q.idx <= pick.blank ? '0 : pick.idx;
         end
      end
   end

   p_flush_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flushing |=> q.blank && q.idx == '0 && !q.hs && !q.vs);
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_cnt <= CNT_W'(FLUSH_LEN));
   p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flushing && pick.blank) |=> q.idx == '0);
endmodule

// File: rtl/vgapt_path.sv
module vgapt_path
   import vgapt_pkg::*;
#(
   parameter int unsigned EXTRA_DLY = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] vga_idx,
   input  logic             vga_blank,
   input  logic             vga_hs,
   input  logic             vga_vs,
   input  logic [IDX_W-1:0] pix_idx,
   input  logic             pix_blank,
   input  logic             pix_hs,
   input  logic             pix_vs,
   input  logic             self_clk,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_data,
   input  logic [1:0]       clk_sel,
   output logic [1:0]       clk_src,
   output logic [IDX_W-1:0] out_idx,
   output logic             out_blank,
   output logic             out_hs,
   output logic             out_vs
);
   localparam int unsigned SRC_BIT = 7;
   localparam logic [1:0]  VGA_CLK_CODE = 2'b00;

   // R2: permitted range of the extra delay
   initial begin
      if (EXTRA_DLY > 7) $error("EXTRA_DLY must be within 0..7");
   end

   logic  vga_en_q;
   beat_t vga_in, pix_in, vga_cap, pix_cap, vga_dly, out_b;

   assign vga_in = '{vs: vga_vs, hs: vga_hs, blank: vga_blank, idx: vga_idx};
   assign pix_in = '{vs: pix_vs, hs: pix_hs, blank: pix_blank, idx: pix_idx};

   always_ff @(posedge clk) begin
      if (!rst_n)      vga_en_q <= 1'b1;
      else if (ctl_wr) vga_en_q <= ctl_data[SRC_BIT];
   end

   assign clk_src = vga_en_q ? VGA_CLK_CODE : clk_sel;

   vgapt_capture u_cap_vga (.clk(clk), .rst_n(rst_n), .d(vga_in), .q(vga_cap));
   vgapt_capture u_cap_pix (.clk(clk), .rst_n(rst_n), .d(pix_in), .q(pix_cap));

   vgapt_delay #(.EXTRA_DLY(EXTRA_DLY)) u_dly (
      .clk(clk), .rst_n(rst_n), .use_extra(self_clk), .d(vga_cap), .q(vga_dly));

   vgapt_outstage #(.EXTRA_DLY(EXTRA_DLY)) u_out (
      .clk(clk), .rst_n(rst_n), .self_clk(self_clk), .use_vga(vga_en_q),
      .vga_b(vga_dly), .pix_b(pix_cap), .q(out_b));

   assign out_idx   = out_b.idx;
   assign out_blank = out_b.blank;
   assign out_hs    = out_b.hs;
   assign out_vs    = out_b.vs;

   p_srcbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> vga_en_q == $past(ctl_data[SRC_BIT]));
   p_clksrc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!vga_en_q) |-> clk_src == clk_sel);
endmodule

// File: tb/vgapt_path_bench.sv
`timescale 1ns/1ps
module vgapt_path_bench;
   localparam int EXTRA = 3;
   localparam int NCYC  = 3000;
   localparam logic [10:0] IDLE = {1'b0, 1'b0, 1'b1, 8'h00};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] vga_idx = '0, pix_idx = '0, ctl_data = '0;
   logic vga_blank = 1'b0, vga_hs = 1'b0, vga_vs = 1'b0;
   logic pix_blank = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
   logic self_clk = 1'b0, ctl_wr = 1'b0;
   logic [1:0] clk_sel = '0, clk_src;
   logic [7:0] out_idx;
   logic out_blank, out_hs, out_vs;

   int compared = 0, mismatched = 0;

   logic [10:0] vh [NCYC];
   logic [10:0] ph [NCYC];
   logic        sh [NCYC];
   logic        en_at [NCYC];

   always #4 clk = ~clk;

   vgapt_path #(.EXTRA_DLY(EXTRA)) u_vgapt_path (
      .clk(clk), .rst_n(rst_n),
      .vga_idx(vga_idx), .vga_blank(vga_blank), .vga_hs(vga_hs), .vga_vs(vga_vs),
      .pix_idx(pix_idx), .pix_blank(pix_blank), .pix_hs(pix_hs), .pix_vs(pix_vs),
      .self_clk(self_clk), .ctl_wr(ctl_wr), .ctl_data(ctl_data), .clk_sel(clk_sel),
      .clk_src(clk_src), .out_idx(out_idx), .out_blank(out_blank),
      .out_hs(out_hs), .out_vs(out_vs));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic self_at(input int m);
      return (m < 0) ? 1'b0 : sh[m];
   endfunction

   function automatic logic flush_at(input int n);
      for (int m = n - EXTRA - 1; m <= n; m++)
         if (m >= 0 && self_at(m) != self_at(m-1)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [10:0] expect_out(input int n);
      logic [10:0] b;
      int k;
      if (flush_at(n)) return IDLE;
      if (en_at[n]) begin
         k = n - 1 - (sh[n] ? EXTRA : 0);
         b = (k < 0) ? IDLE : vh[k];
      end else begin
         b = (n - 1 < 0) ? IDLE : ph[n-1];
      end
      if (b[8]) b[7:0] = 8'h00;
      return b;
   endfunction

   function automatic string tag_for(input int n);
      if (flush_at(n)) return "R8";
      if (n > 0 && en_at[n] != en_at[n-1]) return "R4";
      if (!en_at[n]) return "R3";
      if (sh[n]) return "R2";
      return "R1";
   endfunction

   initial begin
      #(200000 * 8);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic en_cur;
      logic [10:0] e;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R5: reset state
      check("R5", {out_vs, out_hs, out_blank, out_idx}, IDLE);
      check("R5", clk_src, 2'b00);
      rst_n = 1'b1;
      en_cur = 1'b1;
      for (int n = 0; n < NCYC; n++) begin
         // drive inputs for edge n
         vga_idx = 8'($urandom); vga_blank = ($urandom % 4) == 0;
         vga_hs = $urandom % 2;  vga_vs = ($urandom % 8) == 0;
         pix_idx = 8'($urandom); pix_blank = ($urandom % 4) == 0;
         pix_hs = $urandom % 2;  pix_vs = ($urandom % 8) == 0;
         clk_sel = 2'($urandom);
         if (n < 30) self_clk = 1'b0;
         else if (n == 30 || n == 31) self_clk = ~self_clk;          // back-to-back toggle
         else if (n == 60) self_clk = 1'b1;
         else if (n > 80 && ($urandom % 48) == 0) self_clk = ~self_clk;
         ctl_wr = (n == 120) || (n == 200) || (n > 200 && ($urandom % 24) == 0);
         ctl_data = 8'($urandom);
         if (n == 120) ctl_data[7] = 1'b0;
         if (n == 200) ctl_data[7] = 1'b1;
         vh[n] = {vga_vs, vga_hs, vga_blank, vga_idx};
         ph[n] = {pix_vs, pix_hs, pix_blank, pix_idx};
         sh[n] = self_clk;
         en_at[n] = en_cur;
         if (ctl_wr) en_cur = ctl_data[7];
         @(negedge clk);
         e = expect_out(n);
         check(tag_for(n), {out_vs, out_hs, out_blank, out_idx}, e);
         if (out_blank) check("R7", out_idx, 8'h00);
         check("R6", clk_src, en_cur ? 2'b00 : clk_sel);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule